// File: doc/BRIEF.md
# SPI Peripheral with Collision Flag

This block is a byte-wide SPI port that a processor programs through three small registers. It can run as a master or as a slave. The software chooses the clock polarity, the clock phase and the bit order. In master mode, writing a byte to the data register starts a transfer. The block then lowers its slave-select output, sends eight SCLK pulses from a fixed divider of the system clock and shifts the byte out on MOSI. At the same time it gathers the reply from MISO. In slave mode, the byte written beforehand is preloaded into the shifter. An external master then clocks it out on MISO, and the block collects the byte arriving on MOSI.

Completion of every byte sets a sticky done flag, and the received byte can then be read back at the data address. A data write that would corrupt a running byte is refused and sets a sticky collision flag instead. In master mode that is a write while a transfer is running. In slave mode it is a write while slave select is held low. Software clears either flag by writing 1 to its bit.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, sclk_o is 0, ss_n_o is 1, miso_oe is 0, the status register (address 2) reads 0 and the control register (address 1) reads 0, which selects slave mode.
- R2: In master mode (control bit 0 = 1), a write to the data register (address 0) while idle drives ss_n_o low and makes exactly 8 SCLK pulses (16 level changes). Afterwards ss_n_o returns high and sclk_o rests at the idle level given by control bit 1 (0 = low, 1 = high).
- R3: With control bit 2 = 0, the first data bit is valid on the output line from the moment select goes low, half an SCLK period before the first clock edge. Data is sampled on the leading edge (the one leaving the idle level) and shifted on the trailing edge.
- R4: With control bit 2 = 1, the output shifts on the leading edge and the input is sampled on the trailing edge.
- R5: Control bit 3 = 0 sends and assembles each byte most significant bit first; control bit 3 = 1 does it least significant bit first.
- R6: Status bit 0 (done) is set once the eighth bit has been sampled, and the received byte then reads back at address 0.
- R7: Status bits 0 and 1 stay set until software writes 1 to the same bit at address 2. Writing 0 to a bit leaves it unchanged.
- R8: In master mode, a data write during a transfer sets status bit 1 (collision) and does not change the byte being sent.
- R9: In slave mode, a data write while the synchronised ss_n_i is low sets status bit 1 and leaves the preloaded shift contents unchanged.
- R10: In slave mode, sclk_i, mosi_i and ss_n_i each pass through a two-flip-flop synchroniser. miso_oe is high only while the synchronised select is low, and the byte on mosi_i is received as set by R3 to R5.
- R11: After a slave transfer, a data write is refused while select is still low and accepted once select has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| wr_en | input | 1 | Register write strobe, one cycle |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr (combinational) |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master data output |
| mosi_i | input | 1 | Slave data input |
| miso_o | output | 1 | Slave data output |
| miso_i | input | 1 | Master data input |
| miso_oe | output | 1 | Output enable for miso_o |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| ss_n_i | input | 1 | Active-low select received in slave mode |

## Verification
The bench runs all four polarity and phase pairings, mixed with both bit orders, against a bench-side peer. If the edges were swapped, or the first bit were not presented before the first edge, the peer would capture a byte rotated by one bit. It also counts SCLK level changes, so a ninth pulse, or a clock left at the wrong idle level, shows up at once. It writes to the data register in the middle of a master byte and with slave select held low. A design that let those writes through would send the wrong byte or fail to raise the collision flag. Finally it writes 0 and then 1 to the status flags, which catches flags that clear themselves or ignore the clear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned XW     = 8;
    localparam int unsigned HALF_W = $clog2(2 * XW);
    localparam int unsigned CNT_W  = $clog2(XW + 1);

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_CTRL = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } addr_e;

    typedef struct packed {
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic master;
    } ctrl_t;

    typedef struct packed {
        ctrl_t               ctrl;
        logic [XW-1:0]       tx;
        logic [XW-1:0]       rx;
        logic [HALF_W-1:0]   half;
        logic [CNT_W-1:0]    nbits;
        logic                busy;
        logic                sclk;
        logic                ss_n;
        logic                done;
        logic                wcol;
        logic                prev_sclk;
    } state_t;

    // bit currently presented on the serial output
    function automatic logic pick_bit(logic [XW-1:0] v, logic lsb);
        return lsb ? v[0] : v[XW-1];
    endfunction

    // advance the transmit shifter by one position
    function automatic logic [XW-1:0] drop_bit(logic [XW-1:0] v, logic lsb);
        return lsb ? {1'b0, v[XW-1:1]} : {v[XW-2:0], 1'b0};
    endfunction

    // insert a received bit so the byte lands in natural order
    function automatic logic [XW-1:0] take_bit(logic [XW-1:0] v, logic b, logic lsb);
        return lsb ? {b, v[XW-1:1]} : {v[XW-2:0], b};
    endfunction

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/half_tick.sv
module half_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int unsigned DIV_HALF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic [XW-1:0] wdata,
    output logic [XW-1:0] rdata,
    output logic          sclk_o,
    input  logic          sclk_i,
    output logic          mosi_o,
    input  logic          mosi_i,
    output logic          miso_o,
    input  logic          miso_i,
    output logic          miso_oe,
    output logic          ss_n_o,
    input  logic          ss_n_i
);
    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * XW - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(XW);
    localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(XW - 1);

    state_t st_d, st_q;

    addr_e a;
    logic  wr_data, wr_ctrl, wr_stat;
    logic  tick;
    logic  ss_s, sclk_s, mosi_s;
    logic  s_edge, s_lead, s_sample;
    logic  m_lead;
    logic  tx_bit;

    assign a       = addr_e'(addr);
    assign wr_data = wr_en && (a == A_DATA);
    assign wr_ctrl = wr_en && (a == A_CTRL);
    assign wr_stat = wr_en && (a == A_STAT);

    ser_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sclk_i, mosi_i}),
        .q     ({ss_s, sclk_s, mosi_s})
    );

    half_tick #(.DIV(DIV_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy),
        .tick  (tick)
    );

    // master: an even half ending means SCLK leaves its idle level
    assign m_lead   = ~st_q.half[0];
    // slave: edge seen on the synchronised clock
    assign s_edge   = (sclk_s != st_q.prev_sclk);
    assign s_lead   = (sclk_s != st_q.ctrl.cpol);
    assign s_sample = s_lead ^ st_q.ctrl.cpha;
    assign tx_bit   = pick_bit(st_q.tx, st_q.ctrl.lsb_first);

    always_comb begin
        st_d           = st_q;
        st_d.prev_sclk = sclk_s;

        if (wr_stat) begin
            if (wdata[0]) st_d.done = 1'b0;
            if (wdata[1]) st_d.wcol = 1'b0;
        end
        if (wr_ctrl) st_d.ctrl = ctrl_t'(wdata[3:0]);

        if (st_q.ctrl.master) begin
            st_d.nbits = '0;
            if (!st_q.busy) st_d.sclk = st_q.ctrl.cpol;
            if (st_q.busy && tick) begin
                st_d.sclk = ~st_q.sclk;
                if (m_lead) begin
                    if (!st_q.ctrl.cpha)
                        st_d.rx = take_bit(st_q.rx, miso_i, st_q.ctrl.lsb_first);
                    else if (st_q.half != '0)
                        st_d.tx = drop_bit(st_q.tx, st_q.ctrl.lsb_first);
                end else begin
                    if (st_q.ctrl.cpha)
                        st_d.rx = take_bit(st_q.rx, miso_i, st_q.ctrl.lsb_first);
                    else if (st_q.half != LAST_HALF)
                        st_d.tx = drop_bit(st_q.tx, st_q.ctrl.lsb_first);
                end
                if (st_q.half == LAST_HALF) begin
                    st_d.busy = 1'b0;
                    st_d.ss_n = 1'b1;
                    st_d.done = 1'b1;
                    st_d.half = '0;
                end else begin
                    st_d.half = st_q.half + 1'b1;
                end
            end
            if (wr_data) begin
                if (st_q.busy) begin
                    st_d.wcol = 1'b1;
                end else begin
                    st_d.tx   = wdata;
                    st_d.busy = 1'b1;
                    st_d.ss_n = 1'b0;
                    st_d.half = '0;
                end
            end
        end else begin
            st_d.sclk = st_q.ctrl.cpol;
            st_d.busy = 1'b0;
            st_d.ss_n = 1'b1;
            st_d.half = '0;
            if (ss_s) begin
                st_d.nbits = '0;
            end else if (s_edge && (st_q.nbits < FULL_CNT)) begin
                if (s_sample) begin
                    st_d.rx    = take_bit(st_q.rx, mosi_s, st_q.ctrl.lsb_first);
                    st_d.nbits = st_q.nbits + 1'b1;
                    if (st_q.nbits == LAST_CNT) st_d.done = 1'b1;
                end else if (!st_q.ctrl.cpha || (st_q.nbits != '0)) begin
                    st_d.tx = drop_bit(st_q.tx, st_q.ctrl.lsb_first);
                end
            end
            if (wr_data) begin
                if (!ss_s) st_d.wcol = 1'b1;
                else       st_d.tx   = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ss_n <= 1'b1;
        end else begin
            st_q      <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (a)
            A_DATA:  rdata = st_q.rx;
            A_CTRL:  rdata[3:0] = st_q.ctrl;
            A_STAT:  rdata[1:0] = {st_q.wcol, st_q.done};
            default: rdata = '0;
        endcase
    end

    assign sclk_o  = st_q.sclk;
    assign ss_n_o  = st_q.ss_n;
    assign mosi_o  = tx_bit;
    assign miso_o  = tx_bit;
    assign miso_oe = !st_q.ctrl.master && !ss_s;

    // R2: with select idle and polarity steady, the clock rests at idle level
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ss_n && $past(st_q.ss_n) && $stable(st_q.ctrl.cpol))
            |-> (sclk_o == st_q.ctrl.cpol));

    // R6: a master done flag only rises as a running transfer ends
    a_r6_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.done) && st_q.ctrl.master) |-> $past(st_q.busy));

    // R8: data write during a master transfer raises collision
    a_r8_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.master && st_q.busy && wr_data) |=> st_q.wcol);

    // R9: slave write under select low raises collision and keeps the shifter
    a_r9_slave_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.master && !ss_s && wr_data && !s_edge)
            |=> (st_q.wcol && $stable(st_q.tx)));

    // R10: the slave output is never enabled while the master path selects
    a_r10_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> ss_n_o);

endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
    import ssp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SL_HALF    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sclk_o, mosi_o, miso_o, miso_oe, ss_n_o;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int checks = 0;
    int errs   = 0;
    int tog_cnt = 0;
    logic [7:0] exp_q[$];

    sync_serial_port #(.DIV_HALF(4)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o),
        .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i), .miso_oe(miso_oe),
        .ss_n_o(ss_n_o), .ss_n_i(ss_n_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(sclk_o) tog_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd3;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic int idx(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    task automatic wait_done();
        logic [7:0] s;
        for (int n = 0; n < 400; n++) begin
            reg_read(2'd2, s);
            if (s[0]) break;
        end
    endtask

    // monitor: acts as the remote slave, pops the expected byte and compares
    task automatic peer_run(input logic cpol, input logic cpha, input logic lsb,
                            input logic [7:0] reply, input string tag);
        logic [7:0] got = '0;
        logic [7:0] exp;
        wait (ss_n_o == 1'b0);
        if (!cpha) miso_i = reply[idx(0, lsb)];
        for (int i = 0; i < 8; i++) begin
            wait (sclk_o != cpol);
            if (!cpha) got[idx(i, lsb)] = mosi_o;
            else       miso_i = reply[idx(i, lsb)];
            wait (sclk_o == cpol);
            if (!cpha) begin
                if (i < 7) miso_i = reply[idx(i + 1, lsb)];
            end else begin
                got[idx(i, lsb)] = mosi_o;
            end
        end
        wait (ss_n_o == 1'b1);
        exp = exp_q.pop_front();
        chk({tag, " master byte on MOSI"}, got, exp);
    endtask

    // driver: programs a master transfer and pushes what the peer must see
    task automatic master_case(input logic [3:0] ctl, input logic [7:0] tx,
                               input logic [7:0] reply, input bit mid_write,
                               input string tag);
        logic [7:0] r;
        reg_write(2'd1, {4'h0, ctl});
        reg_write(2'd2, 8'h03);
        repeat (3) @(negedge clk);
        tog_cnt = 0;
        exp_q.push_back(tx);
        fork
            peer_run(ctl[1], ctl[2], ctl[3], reply, tag);
            begin
                reg_write(2'd0, tx);
                if (mid_write) begin
                    repeat (12) @(negedge clk);
                    reg_write(2'd0, ~tx);
                end
            end
        join
        wait_done();
        reg_read(2'd0, r);
        chk({tag, " R6 received byte"}, r, reply);
        chk("R2 sixteen clock level changes", tog_cnt, 16);
        chk("R2 clock back at idle level", sclk_o, ctl[1]);
        chk("R2 select released", ss_n_o, 1'b1);
        reg_read(2'd2, r);
        chk("R6 done flag set", r[0], 1'b1);
        chk(mid_write ? "R8 collision on busy write" : "R8 no collision",
            r[1], mid_write);
    endtask

    task automatic slave_frame(input logic cpol, input logic cpha, input logic lsb,
                               input logic [7:0] mb, input bit release_ss,
                               output logic [7:0] sb);
        sb = '0;
        sclk_i = cpol;
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (SL_HALF) @(negedge clk);
        if (!cpha) mosi_i = mb[idx(0, lsb)];
        for (int i = 0; i < 8; i++) begin
            sclk_i = ~cpol;
            if (!cpha) sb[idx(i, lsb)] = miso_o;
            else       mosi_i = mb[idx(i, lsb)];
            repeat (SL_HALF) @(negedge clk);
            sclk_i = cpol;
            if (!cpha) begin
                if (i < 7) mosi_i = mb[idx(i + 1, lsb)];
            end else begin
                sb[idx(i, lsb)] = miso_o;
            end
            repeat (SL_HALF) @(negedge clk);
        end
        if (release_ss) begin
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] sb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sclk_o idle", sclk_o, 1'b0);
        chk("R1 ss_n_o high", ss_n_o, 1'b1);
        chk("R1 miso_oe low", miso_oe, 1'b0);
        reg_read(2'd2, r);
        chk("R1 status clear", r, 8'h00);
        reg_read(2'd1, r);
        chk("R1 control clear", r, 8'h00);

        // R3 R5: pol 0, phase 0, MSB first
        master_case(4'h1, 8'hA5, 8'h3C, 1'b0, "R3 R5 msb p0");
        // R3 R5: pol 1, phase 0, LSB first
        master_case(4'hB, 8'h1E, 8'hC7, 1'b0, "R3 R5 lsb p1");
        // R4 R5: pol 0, phase 1, LSB first
        master_case(4'hD, 8'h6B, 8'h92, 1'b0, "R4 R5 lsb p0");
        // R4: pol 1, phase 1, MSB first
        master_case(4'h7, 8'hF0, 8'h0F, 1'b0, "R4 msb p1");
        // R8: write during a running byte
        master_case(4'h1, 8'h55, 8'hAA, 1'b1, "R8 collision");

        // R7: writing 0 keeps the flags, writing 1 clears them
        reg_write(2'd2, 8'h00);
        reg_read(2'd2, r);
        chk("R7 flags kept on zero write", r[1:0], 2'b11);
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, r);
        chk("R7 done cleared alone", r[1:0], 2'b10);
        reg_write(2'd2, 8'h02);
        reg_read(2'd2, r);
        chk("R7 collision cleared", r[1:0], 2'b00);

        // slave mode, pol 0, phase 0, MSB first
        reg_write(2'd1, 8'h00);
        repeat (4) @(negedge clk);
        reg_write(2'd0, 8'h5A);
        chk("R10 miso_oe low with select high", miso_oe, 1'b0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 miso_oe high with select low", miso_oe, 1'b1);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd2, r);
        chk("R9 collision on slave write", r[1], 1'b1);
        slave_frame(1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, sb);
        chk("R9 shift contents kept", sb, 8'h5A);
        repeat (6) @(negedge clk);
        reg_read(2'd0, r);
        chk("R10 slave received byte", r, 8'hC3);
        reg_read(2'd2, r);
        chk("R6 slave done flag", r[0], 1'b1);

        // R11: refused while select still low, accepted after release
        reg_write(2'd2, 8'h03);
        reg_write(2'd0, 8'h81);
        reg_read(2'd2, r);
        chk("R11 refused while select low", r[1], 1'b1);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 miso_oe drops after release", miso_oe, 1'b0);
        reg_write(2'd2, 8'h03);
        reg_write(2'd1, 8'h0E);
        reg_write(2'd0, 8'h81);
        reg_read(2'd2, r);
        chk("R11 accepted after release", r[1], 1'b0);
        slave_frame(1'b1, 1'b1, 1'b1, 8'h96, 1'b1, sb);
        chk("R11 R4 R5 slave sent new byte", sb, 8'h81);
        reg_read(2'd0, r);
        chk("R10 R5 slave received lsb first", r, 8'h96);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule